// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A single-clock synchronous static memory with a two-stage, late-write pipeline. Every operation is split into a command phase and a data phase. Address and control are sampled on a rising edge. The data for that operation moves on the bus two edges later, whether it is a read or a write. Because write data trails its address by the same distance as read data, a controller can place reads and writes on consecutive cycles in any order, and the data bus never needs an idle cycle to turn around.

A burst engine produces four beats from one loaded address. The advance/load pin either starts a new access or steps the burst. The order input picks between a wrapping increment and an XOR sequence on the two low address bits. The block also has:
- three chip selects of mixed polarity,
- a clock enable that freezes the whole pipeline,
- per-lane write enables,
- an output enable that acts at once, without waiting for a clock,
- a sleep input that blocks new work and keeps the stored data.

The bidirectional data bus is split into an input, an output and a drive-enable signal.

Top module: `zt_burst_sram`

## Requirements
- R1: An operation sampled at rising edge k has its data phase in the cycle that ends at edge k+2. A read (`rd_wr`=1) drives `dq_out` with `dq_oe` high through that cycle. A write (`rd_wr`=0) stores `dq_in` at edge k+2.
- R2: Reads and writes can be issued on consecutive enabled cycles in any mix with no idle cycle. A read of an address written by the operation issued one cycle earlier returns the newly written lanes.
- R3: While `clk_en_n` is high, all other synchronous inputs are ignored. No pipeline stage, burst state or memory word changes, and `dq_out`/`dq_oe` hold their previous values.
- R4: With `adv_nld` low, a new address and command are taken. With `adv_nld` high, the burst steps and the address, `rd_wr` and lane-enable pins are ignored. Stepping when no burst is live issues nothing.
- R5: Beat n (n = 0..3) of a burst sets the two low address bits to start+n mod 4 when the order input was 0 at load, and to start XOR n when it was 1. The order is captured at load. Beats keep cycling through the same four offsets past the fourth beat.
- R6: Every beat of a burst inherits the read/write type and lane enables of its load, and keeps the upper address bits of the loaded address.
- R7: A load starts an operation only when `sel_n_a`=0, `sel_b`=1 and `sel_n_c`=0. Otherwise the load issues nothing and ends any live burst, while operations already issued still complete.
- R8: `dq_oe` is low during the data phase of a deselected or idle slot and during the data phase of a write.
- R9: While `out_en_n` is high, `dq_oe` is low at once, within the same cycle and regardless of the pipeline.
- R10: `lane_we_n[i]` (active low) guards data bits [8i+7:8i]. A write changes only the lanes enabled at its load, and the other lanes keep their stored bytes.
- R11: While `sleep` is high, loads and burst steps issue nothing, any live burst ends, `dq_oe` is low, operations already issued still complete and memory is kept. Normal issue resumes on the first enabled cycle after `sleep` falls.
- R12: Synchronous reset empties the pipeline, ends any burst and drives `dq_oe` low. Stored memory words are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Word address, taken on a load |
| rd_wr | input | 1 | 1 = read, 0 = write, taken on a load |
| lane_we_n | input | 2 | Active-low byte-lane write enables |
| sel_n_a | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_n_c | input | 1 | Chip select, active low |
| clk_en_n | input | 1 | Active-low clock enable |
| adv_nld | input | 1 | 0 = load new access, 1 = advance burst |
| order_il | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Power-down request |
| dq_in | input | 16 | Data bus, inbound |
| dq_out | output | 16 | Data bus, outbound |
| dq_oe | output | 1 | Drive enable for the outbound data |

## Verification
A corrupted command stage shows up two enabled edges later, as a wrong `dq_oe` value or wrong read data in the next data phase. A wrong burst counter or a wrong latched order gives a wrong word in the first misplaced beat. A missing forward from a write to the read right behind it shows in the very next data phase as stale lanes. A write that lands on the wrong lane or address stays hidden until that word is read back, so the traffic rereads a small address pool often to keep that delay short. A stall that leaks state changes the outputs on the first enabled cycle after the stall.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int ZT_AW     = 6;
    localparam int ZT_LANES  = 2;
    localparam int ZT_LANE_W = 8;
    localparam int ZT_DW     = ZT_LANES * ZT_LANE_W;
    localparam int ZT_BEATS  = 4;
    localparam int ZT_BW     = $clog2(ZT_BEATS);

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic                vld;
        logic                wr;
        logic [ZT_AW-1:0]    addr;
        logic [ZT_LANES-1:0] lanes;
    } zt_op_t;

    // low-bit offset of a burst beat
    function automatic logic [ZT_BW-1:0] beat_offset(
        input logic [ZT_BW-1:0] start,
        input logic [ZT_BW-1:0] beat,
        input burst_order_e     ord
    );
        return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
    endfunction

    function automatic logic [ZT_AW-1:0] beat_addr(
        input logic [ZT_AW-1:0] base,
        input logic [ZT_BW-1:0] beat,
        input burst_order_e     ord
    );
        logic [ZT_AW-1:0] a;
        a            = base;
        a[ZT_BW-1:0] = beat_offset(base[ZT_BW-1:0], beat, ord);
        return a;
    endfunction

    // replace the enabled lanes of old_w with those of new_w
    function automatic logic [ZT_DW-1:0] lane_merge(
        input logic [ZT_DW-1:0]    old_w,
        input logic [ZT_DW-1:0]    new_w,
        input logic [ZT_LANES-1:0] lanes
    );
        logic [ZT_DW-1:0] r;
        r = old_w;
        for (int i = 0; i < ZT_LANES; i++) begin
            if (lanes[i]) r[i*ZT_LANE_W +: ZT_LANE_W] = new_w[i*ZT_LANE_W +: ZT_LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/zt_issue.sv
module zt_issue
    import zt_sram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic                sleep,
    input  logic                adv,
    input  logic                sel_ok,
    input  logic [ZT_AW-1:0]    addr,
    input  logic                rd_wr,
    input  logic [ZT_LANES-1:0] lane_we_n,
    input  logic                order_il,
    output zt_op_t              cur_op
);

    zt_op_t           base_q, base_d, op_d;
    logic             live_q, live_d;
    logic [ZT_BW-1:0] beat_q, beat_d;
    burst_order_e     ord_q, ord_d;

    always_comb begin
        op_d   = '0;
        base_d = base_q;
        live_d = live_q;
        beat_d = beat_q;
        ord_d  = ord_q;
        if (sleep) begin
            live_d = 1'b0;
        end else if (!adv) begin
            if (sel_ok) begin
                op_d.vld   = 1'b1;
                op_d.wr    = ~rd_wr;
                op_d.addr  = addr;
                op_d.lanes = ~lane_we_n;
                base_d     = op_d;
                live_d     = 1'b1;
                beat_d     = '0;
                ord_d      = burst_order_e'(order_il);
            end else begin
                live_d = 1'b0;
            end
        end else if (live_q) begin
            beat_d    = beat_q + 1'b1;
            op_d      = base_q;
            op_d.addr = beat_addr(base_q.addr, beat_d, ord_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op <= '0;
            base_q <= '0;
            live_q <= 1'b0;
            beat_q <= '0;
            ord_q  <= ORD_WRAP;
        end else if (step) begin
            cur_op <= op_d;
            base_q <= base_d;
            live_q <= live_d;
            beat_q <= beat_d;
            ord_q  <= ord_d;
        end
    end

endmodule

// File: rtl/zt_mem_lanes.sv
module zt_mem_lanes #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
    end

endmodule

// File: rtl/zt_read_port.sv
module zt_read_port
    import zt_sram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             rd_pend,
    input  logic [ZT_AW-1:0] rd_addr,
    input  zt_op_t           phase_op,
    input  logic [ZT_DW-1:0] array_q,
    input  logic [ZT_DW-1:0] bus_in,
    output logic [ZT_DW-1:0] rd_q
);

    logic             fwd_hit;
    logic [ZT_DW-1:0] fresh;

    // a write finishing on this edge to the same word must be seen
    always_comb begin
        fwd_hit = phase_op.vld && phase_op.wr && (phase_op.addr == rd_addr);
        fresh   = fwd_hit ? lane_merge(array_q, bus_in, phase_op.lanes) : array_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                  rd_q <= '0;
        else if (step && rd_pend) rd_q <= fresh;
    end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ZT_AW-1:0]    addr,
    input  logic                rd_wr,
    input  logic [ZT_LANES-1:0] lane_we_n,
    input  logic                sel_n_a,
    input  logic                sel_b,
    input  logic                sel_n_c,
    input  logic                clk_en_n,
    input  logic                adv_nld,
    input  logic                order_il,
    input  logic                out_en_n,
    input  logic                sleep,
    input  logic [ZT_DW-1:0]    dq_in,
    output logic [ZT_DW-1:0]    dq_out,
    output logic                dq_oe
);

    logic             step;
    logic             ce_ok;
    zt_op_t           p1, p2;
    logic [ZT_DW-1:0] array_q;
    logic             wr_fire;

    assign step    = ~clk_en_n;
    assign ce_ok   = ~sel_n_a & sel_b & ~sel_n_c;
    assign wr_fire = step & p2.vld & p2.wr;

    zt_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .sleep     (sleep),
        .adv       (adv_nld),
        .sel_ok    (ce_ok),
        .addr      (addr),
        .rd_wr     (rd_wr),
        .lane_we_n (lane_we_n),
        .order_il  (order_il),
        .cur_op    (p1)
    );

    always_ff @(posedge clk) begin
        if (rst)       p2 <= '0;
        else if (step) p2 <= p1;
    end

    zt_mem_lanes #(
        .AW     (ZT_AW),
        .LANES  (ZT_LANES),
        .LANE_W (ZT_LANE_W)
    ) u_mem (
        .clk      (clk),
        .wr_en    (wr_fire),
        .wr_addr  (p2.addr),
        .wr_lanes (p2.lanes),
        .wr_data  (dq_in),
        .rd_addr  (p1.addr),
        .rd_data  (array_q)
    );

    zt_read_port u_rport (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .rd_pend  (p1.vld & ~p1.wr),
        .rd_addr  (p1.addr),
        .phase_op (p2),
        .array_q  (array_q),
        .bus_in   (dq_in),
        .rd_q     (dq_out)
    );

    assign dq_oe = p2.vld & ~p2.wr & ~out_en_n & ~sleep;

endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk
    import zt_sram_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clk_en_n,
    input logic             adv_nld,
    input logic             sleep,
    input logic             out_en_n,
    input logic             ce_ok,
    input logic             dq_oe,
    input logic [ZT_DW-1:0] dq_out,
    input zt_op_t           p1,
    input zt_op_t           p2
);

    // R1: the command stage moves into the data-phase stage on each enabled edge
    p_pipe_advance_r1: assert property (@(posedge clk) disable iff (rst)
        !clk_en_n |=> (p2 == $past(p1)));

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(p1) && $stable(p2) && $stable(dq_out)));

    p_burst_inherit_r6: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && adv_nld && !sleep && p1.vld) |=>
        (p1.vld && p1.wr == $past(p1.wr) && p1.lanes == $past(p1.lanes) &&
         p1.addr[ZT_AW-1:ZT_BW] == $past(p1.addr[ZT_AW-1:ZT_BW])));

    p_desel_noissue_r7: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_nld && !ce_ok) |=> !p1.vld);

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (p2.vld && p2.wr) |-> !dq_oe);

    p_oe_async_r9: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dq_oe);

    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);

    p_sleep_noissue_r11: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && sleep) |=> !p1.vld);

endmodule

bind zt_burst_sram zt_burst_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .adv_nld  (adv_nld),
    .sleep    (sleep),
    .out_en_n (out_en_n),
    .ce_ok    (ce_ok),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .p1       (p1),
    .p2       (p2)
);

// File: tb/zt_burst_sram_tb.sv
module zt_burst_sram_tb;
    import zt_sram_pkg::*;

    localparam int DEPTH = 1 << ZT_AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [ZT_AW-1:0]    addr      = '0;
    logic                rd_wr     = 1'b1;
    logic [ZT_LANES-1:0] lane_we_n = '1;
    logic                sel_n_a   = 1'b0;
    logic                sel_b     = 1'b1;
    logic                sel_n_c   = 1'b0;
    logic                clk_en_n  = 1'b0;
    logic                adv_nld   = 1'b0;
    logic                order_il  = 1'b0;
    logic                out_en_n  = 1'b0;
    logic                sleep     = 1'b0;
    logic [ZT_DW-1:0]    dq_in     = '0;
    logic [ZT_DW-1:0]    dq_out;
    logic                dq_oe;

    zt_burst_sram u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_wr(rd_wr), .lane_we_n(lane_we_n),
        .sel_n_a(sel_n_a), .sel_b(sel_b), .sel_n_c(sel_n_c), .clk_en_n(clk_en_n),
        .adv_nld(adv_nld), .order_il(order_il), .out_en_n(out_en_n), .sleep(sleep),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        bit                vld;
        bit                wr;
        int                addr;
        bit [ZT_LANES-1:0] lanes;
    } bop_t;

    bop_t             pipe_q[$];
    logic [ZT_DW-1:0] m_mem [DEPTH];
    logic [ZT_DW-1:0] exp_dat = '0;
    bit               b_live = 0;
    bop_t             b_base;
    int               b_beat = 0;
    bit               b_xor  = 0;
    int               n_checks = 0;
    int               n_errs   = 0;
    string            tag = "R12";

    // behavioural reference: a two-deep queue of issued operations
    always @(posedge clk) begin : ref_model
        bop_t iss;
        bop_t ph;
        if (rst) begin
            pipe_q.delete();
            pipe_q.push_back('{0, 0, 0, 0});
            pipe_q.push_back('{0, 0, 0, 0});
            b_live = 0;
        end else if (!clk_en_n) begin
            ph = pipe_q[0];
            if (ph.vld && ph.wr) begin
                for (int l = 0; l < ZT_LANES; l++)
                    if (ph.lanes[l]) m_mem[ph.addr][l*ZT_LANE_W +: ZT_LANE_W] = dq_in[l*ZT_LANE_W +: ZT_LANE_W];
            end
            iss = '{0, 0, 0, 0};
            if (sleep) begin
                b_live = 0;
            end else if (!adv_nld) begin
                if (!sel_n_a && sel_b && !sel_n_c) begin
                    iss    = '{1, !rd_wr, int'(addr), ~lane_we_n};
                    b_base = iss;
                    b_live = 1;
                    b_beat = 0;
                    b_xor  = order_il;
                end else begin
                    b_live = 0;
                end
            end else if (b_live) begin
                int lo;
                b_beat = (b_beat + 1) % 4;
                lo     = b_xor ? ((b_base.addr % 4) ^ b_beat) : ((b_base.addr + b_beat) % 4);
                iss    = b_base;
                iss.addr = (b_base.addr / 4) * 4 + lo;
            end
            void'(pipe_q.pop_front());
            pipe_q.push_back(iss);
            if (pipe_q[0].vld && !pipe_q[0].wr) exp_dat = m_mem[pipe_q[0].addr];
        end
    end

    task automatic chk_out();
        bit e_oe;
        e_oe = pipe_q.size() == 2 && pipe_q[0].vld && !pipe_q[0].wr && !out_en_n && !sleep;
        n_checks++;
        if (dq_oe !== e_oe) begin
            n_errs++;
            $display("FAIL %s dq_oe actual=%0b expected=%0b t=%0t", tag, dq_oe, e_oe, $time);
        end
        if (e_oe) begin
            n_checks++;
            if (dq_out !== exp_dat) begin
                n_errs++;
                $display("FAIL %s dq_out actual=%h expected=%h t=%0t", tag, dq_out, exp_dat, $time);
            end
        end
    endtask

    task automatic step(input string t, input bit ld, input bit rd, input int a,
                        input logic [ZT_LANES-1:0] wen_n, input bit ce, input bit stall,
                        input bit il, input bit slp, input bit oen);
        @(negedge clk);
        tag = t;
        chk_out();
        adv_nld   = !ld;
        rd_wr     = rd;
        addr      = a[ZT_AW-1:0];
        lane_we_n = wen_n;
        sel_n_a   = 1'b0;
        sel_b     = 1'b1;
        sel_n_c   = 1'b0;
        if (!ce) begin
            case ($urandom % 3)
                0:       sel_n_a = 1'b1;
                1:       sel_b   = 1'b0;
                default: sel_n_c = 1'b1;
            endcase
        end
        clk_en_n = stall;
        order_il = il;
        sleep    = slp;
        out_en_n = oen;
        dq_in    = ZT_DW'($urandom);
    endtask

    task automatic idle(input string t, input int n);
        for (int i = 0; i < n; i++) step(t, 1, 1, 0, '1, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: empty pipeline after reset
        @(negedge clk);
        tag = "R12";
        chk_out();

        // R1: fill every word, then read all back-to-back
        for (int a = 0; a < DEPTH; a++) step("R1", 1, 0, a, '0, 1, 0, 0, 0, 0);
        for (int a = 0; a < DEPTH; a++) step("R1", 1, 1, a, '1, 1, 0, 0, 0, 0);

        // R2 / R10: dense mixed traffic on a small pool, partial lanes
        for (int i = 0; i < 400; i++)
            step((i % 2) ? "R2" : "R10", 1, $urandom % 2, $urandom % 6,
                 ZT_LANES'($urandom), 1, 0, 0, 0, 0);
        for (int a = 0; a < 6; a++) step("R10", 1, 1, a, '1, 1, 0, 0, 0, 0);

        // R3: random stalls with garbage on the inputs
        for (int i = 0; i < 400; i++)
            step("R3", $urandom % 2, $urandom % 2, $urandom % 8, ZT_LANES'($urandom),
                 ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 2, 0, 0);

        // R5 / R6: bursts in both orders, beyond four beats
        for (int b = 0; b < 60; b++) begin
            step("R6", 1, $urandom % 2, $urandom % DEPTH, ZT_LANES'($urandom), 1, 0,
                 b % 2, 0, 0);
            for (int k = 0; k < 3 + ($urandom % 5); k++)
                step("R5", 0, $urandom % 2, $urandom % DEPTH, ZT_LANES'($urandom),
                     1, ($urandom % 5) == 0, $urandom % 2, 0, 0);
        end

        // R4: advance with no live burst
        idle("R4", 2);
        for (int i = 0; i < 6; i++) step("R4", 0, 1, $urandom % DEPTH, '0, 1, 0, 0, 0, 0);

        // R7 / R8: deselects mixed into traffic
        for (int i = 0; i < 300; i++)
            step((i % 2) ? "R7" : "R8", ($urandom % 4) != 0, $urandom % 2, $urandom % 8,
                 ZT_LANES'($urandom), ($urandom % 3) != 0, 0, $urandom % 2, 0, 0);

        // R9: output enable toggling, plus mid-cycle release
        for (int i = 0; i < 200; i++)
            step("R9", 1, $urandom % 2, $urandom % 8, ZT_LANES'($urandom), 1, 0, 0, 0,
                 $urandom % 2);
        for (int i = 0; i < 6; i++) begin
            step("R9", 1, 1, i, '1, 1, 0, 0, 0, 0);
            @(posedge clk);
            #2;
            out_en_n = 1'b1;
            #1;
            n_checks++;
            if (dq_oe !== 1'b0) begin
                n_errs++;
                $display("FAIL R9 async dq_oe actual=%0b expected=0", dq_oe);
            end
            out_en_n = 1'b0;
        end

        // R11: sleep spans over live traffic and bursts
        for (int i = 0; i < 300; i++)
            step("R11", ($urandom % 3) != 0, $urandom % 2, $urandom % 8, ZT_LANES'($urandom),
                 1, ($urandom % 6) == 0, $urandom % 2, ((i / 7) % 3) == 1, 0);
        for (int a = 0; a < 8; a++) step("R11", 1, 1, a, '1, 1, 0, 0, 0, 0);

        // R12: reset mid-traffic keeps memory
        step("R12", 1, 0, 3, '0, 1, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 8; a++) step("R12", 1, 1, a, '1, 1, 0, 0, 0, 0);
        idle("R12", 4);

        finish_run();
    end

endmodule